// File: doc/BRIEF.md
# Serial Bitstream Configuration Master

This block is the loading side of a serial configuration link. It drives a clock toward an external serial memory, takes one data bit from that memory on each rising edge of this clock, and packs the bits into bytes. Two handshake outputs steer the memory directly. An active-low initialisation output is tied to the memory's reset and rewinds the memory's address pointer. A completion output is tied to the memory's active-low chip enable, so the memory is enabled for as long as loading is in progress.

Loading begins on its own once the system reset is released. A long enough low pulse on the program-request input restarts it from any state. A rate input chooses between a slow and a fast configuration clock, both divided down from the system clock. With a 40 MHz system clock the default dividers give 1.25 MHz and 10 MHz. The expected number of bits is an input. Once that many bits have been taken, the clock stops low and the completion output rises.

Top module: `serial_cfg_loader`

## Requirements
- R1: While rst_n is low, init_n, done, cclk and frame_valid are all 0. After release the block spends one cycle idle and then enters initialisation without any other stimulus.
- R2: Each rising edge of cclk takes exactly one bit from din. A load produces exactly bit_total rising edges of cclk, and cclk never rises while init_n is low or done is high. bit_total is at least 1 and is captured when loading begins.
- R3: When loading begins, rate_sel is captured. A value of 1 gives a cclk period of SLOW_DIV system cycles and a value of 0 gives FAST_DIV cycles, each with a 50% duty cycle.
- R4: Bits are shifted in MSB first, so the first bit of each group of eight lands in frame_data[7]. frame_valid is high for exactly one cycle per completed byte, and frame_count rises by one with each strobe.
- R5: After reset is released, init_n stays low for INIT_CYCLES cycles. After a program request is released, it stays low for the whole request plus INIT_CYCLES cycles. Outside these periods init_n is high.
- R6: When the last bit has been taken, cclk finishes its high phase and then stays low. done then goes high and stays high until the next request. done is low in every other state.
- R7: A low pulse on prgm_n lasting fewer than GLITCH_MIN system cycles has no effect. done, init_n and frame_count keep their values.
- R8: A low pulse on prgm_n lasting GLITCH_MIN cycles or more restarts the block from any state, including in the middle of a load. It drives init_n low, drives done low and clears frame_count to 0. Because the memory pointer is rewound, the next load starts again from the first byte.
- R9: When bit_total is not a multiple of 8, the trailing partial byte produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, acts as power-on reset |
| prgm_n | input | 1 | Active-low program request, asynchronous to clk |
| rate_sel | input | 1 | 1 selects the slow configuration clock, 0 the fast one |
| din | input | 1 | Serial data from the memory |
| bit_total | input | CNT_W | Number of bits to load |
| cclk | output | 1 | Configuration clock to the memory |
| init_n | output | 1 | Low during initialisation; resets the memory pointer |
| done | output | 1 | High when loading is complete; disables the memory |
| frame_data | output | FRAME_W | Last completed byte, first bit in the MSB |
| frame_valid | output | 1 | One-cycle strobe for each completed byte |
| frame_count | output | FCNT_W | Number of bytes completed in this load |

## Verification
A fault in the divider shows up in the spacing of cclk rising edges by the second edge of a load. A fault in the bit counter shows up as the wrong number of edges, or as done rising too early or too late, by the end of that load. A fault in the shift register or the byte counter shows up at the first frame_valid strobe, because the scoreboard compares each byte against the memory image in order. A fault in the request filter shows up within a few cycles of a short or long prgm_n pulse, as a false restart or a missed one.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int SLOW_DIV    = 32,
  parameter int FAST_DIV    = 4,
  parameter int INIT_CYCLES = 16,
  parameter int GLITCH_MIN  = 20,
  parameter int FRAME_W     = 8,
  parameter int CNT_W       = 16,
  parameter int FCNT_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prgm_n,
  input  logic              rate_sel,
  input  logic              din,
  input  logic [CNT_W-1:0]  bit_total,
  output logic              cclk,
  output logic              init_n,
  output logic              done,
  output logic [FRAME_W-1:0] frame_data,
  output logic              frame_valid,
  output logic [FCNT_W-1:0] frame_count
);
  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int DIV_W   = $clog2(MAX_DIV);
  localparam int INIT_W  = $clog2(INIT_CYCLES + 1);
  localparam int GL_W    = $clog2(GLITCH_MIN + 1);
  localparam int FB_W    = $clog2(FRAME_W);

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_LOAD, S_DONE} state_t;

  state_t             st;
  logic [1:0]         psync;
  logic [GL_W-1:0]    low_cnt;
  logic               prog_hold;
  logic [INIT_W-1:0]  tmr;
  logic [DIV_W-1:0]   div_cnt, div_lim;
  logic [CNT_W-1:0]   bit_cnt, total;
  logic [FB_W-1:0]    fbit;
  logic [FRAME_W-2:0] shreg;
  logic [FRAME_W-1:0] nxt;

  assign prog_hold = (low_cnt == GL_W'(GLITCH_MIN));
  assign nxt       = {shreg, din};
  assign init_n    = !(st == S_IDLE || st == S_INIT);
  assign done      = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psync   <= 2'b11;
      low_cnt <= '0;
    end else begin
      psync <= {psync[0], prgm_n};
      if (psync[1])        low_cnt <= '0;
      else if (!prog_hold) low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      tmr         <= '0;
      div_cnt     <= '0;
      div_lim     <= '0;
      bit_cnt     <= '0;
      total       <= '0;
      fbit        <= '0;
      shreg       <= '0;
      cclk        <= 1'b0;
      frame_data  <= '0;
      frame_valid <= 1'b0;
      frame_count <= '0;
    end else begin
      frame_valid <= 1'b0;
      if (prog_hold) begin
        st          <= S_INIT;
        tmr         <= '0;
        cclk        <= 1'b0;
        frame_count <= '0;
      end else begin
        case (st)
          S_IDLE: begin
            st          <= S_INIT;
            tmr         <= '0;
            frame_count <= '0;
          end
          S_INIT: begin
            if (tmr == INIT_W'(INIT_CYCLES - 1)) begin
              st      <= S_LOAD;
              div_lim <= rate_sel ? DIV_W'(SLOW_DIV - 1) : DIV_W'(FAST_DIV - 1);
              total   <= bit_total;
              bit_cnt <= '0;
              div_cnt <= '0;
              fbit    <= '0;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          S_LOAD: begin
            div_cnt <= (div_cnt == div_lim) ? '0 : div_cnt + 1'b1;
            if (div_cnt == (div_lim >> 1)) begin
              cclk    <= 1'b1;
              shreg   <= nxt[FRAME_W-2:0];
              bit_cnt <= bit_cnt + 1'b1;
              if (fbit == FB_W'(FRAME_W - 1)) begin
                fbit        <= '0;
                frame_data  <= nxt;
                frame_valid <= 1'b1;
                frame_count <= frame_count + 1'b1;
              end else begin
                fbit <= fbit + 1'b1;
              end
            end
            if (div_cnt == div_lim) begin
              cclk <= 1'b0;
              if (bit_cnt == total) st <= S_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module serial_cfg_loader_chk #(
  parameter int FCNT_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cclk,
  input logic              init_n,
  input logic              done,
  input logic              frame_valid,
  input logic [FCNT_W-1:0] frame_count
);
  p_rise_in_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk) |-> (init_n && !done));
  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> frame_count == $past(frame_count) + 1'b1);
  p_init_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |-> (!done && !cclk));
  p_done_clk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cclk);
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(.FCNT_W(FCNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cclk(cclk), .init_n(init_n), .done(done),
  .frame_valid(frame_valid), .frame_count(frame_count)
);

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb_top;
  localparam int SLOW = 32, FAST = 4, INITC = 16, GMIN = 20;

  logic clk = 0, rst_n = 0, prgm_n = 1, rate_sel = 0, din;
  logic [15:0] bit_total = 16'd32;
  logic cclk, init_n, done, frame_valid;
  logic [7:0]  frame_data;
  logic [11:0] frame_count;

  serial_cfg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .prgm_n(prgm_n), .rate_sel(rate_sel), .din(din),
    .bit_total(bit_total), .cclk(cclk), .init_n(init_n), .done(done),
    .frame_data(frame_data), .frame_valid(frame_valid), .frame_count(frame_count)
  );

  always #10 clk = ~clk;

  logic [7:0] rom [8] = '{8'hA5, 8'h3C, 8'h81, 8'h7E, 8'hF0, 8'h0F, 8'h55, 8'hC3};
  int ptr = 0;
  always @(posedge cclk or negedge init_n)
    if (!init_n) ptr <= 0; else ptr <= ptr + 1;
  assign din = done ? 1'b0 : rom[(ptr >> 3) & 7][7 - (ptr & 7)];

  int checks = 0, fails = 0, cyc = 0;
  int rises = 0, last_rise = -1, pmin = 0, pmax = 0, exp_fc = 0;
  logic [7:0] exp_q [$];

  always @(posedge clk) cyc++;

  always @(posedge cclk) begin
    rises++;
    if (last_rise >= 0) begin
      if (pmin == 0 || cyc - last_rise < pmin) pmin = cyc - last_rise;
      if (cyc - last_rise > pmax) pmax = cyc - last_rise;
    end
    last_rise = cyc;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && frame_valid) begin
      logic [7:0] e;
      exp_fc++;
      if (exp_q.size() == 0) check(0, "R9", "unexpected frame", frame_data, 0);
      else begin
        e = exp_q.pop_front();
        check(frame_data == e, "R4", "frame byte", frame_data, e);
      end
      check(frame_count == 12'(exp_fc), "R4", "frame_count", frame_count, exp_fc);
    end
  end

  task automatic expect_load(input int nbits);
    exp_q.delete();
    exp_fc = 0;
    for (int i = 0; i < nbits / 8; i++) exp_q.push_back(rom[i]);
    rises = 0; last_rise = -1; pmin = 0; pmax = 0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk) prgm_n = 0;
    repeat (n) @(negedge clk);
    prgm_n = 1;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic finish_load(input string tag, input int nbits, input int per, input int nfr);
    wait_done();
    check(done == 1'b1, "R6", {tag, " done"}, done, 1);
    check(rises == nbits, "R2", {tag, " cclk edges"}, rises, nbits);
    check(pmin == per && pmax == per, "R3", {tag, " cclk period"}, pmax, per);
    check(frame_count == 12'(nfr), "R9", {tag, " frames"}, frame_count, nfr);
    check(exp_q.size() == 0, "R4", {tag, " pending"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    expect_load(32);
    repeat (4) @(negedge clk);
    check(!init_n && !done && !cclk && !frame_valid, "R1", "reset outputs",
          {init_n, done, cclk, frame_valid}, 0);
    rst_n = 1;
    n = 0;
    @(negedge clk);
    while (!init_n && n < 1000) begin n++; @(negedge clk); end
    check(n == INITC, "R5", "init_n low after reset", n, INITC);

    finish_load("fast", 32, FAST, 4);
    repeat (50) @(negedge clk);
    check(done && !cclk && rises == 32, "R6", "clock parked after done", rises, 32);

    pulse(GMIN - 2);
    repeat (10) @(negedge clk);
    check(done && init_n && frame_count == 12'd4, "R7", "short pulse ignored",
          frame_count, 4);

    rate_sel = 1; bit_total = 16'd20;
    expect_load(20);
    @(negedge clk) prgm_n = 0;
    repeat (GMIN + 6) @(negedge clk);
    check(!init_n && !done && frame_count == 0, "R8", "restart from done",
          frame_count, 0);
    prgm_n = 1;
    finish_load("slow", 20, SLOW, 2);

    rate_sel = 0; bit_total = 16'd40;
    expect_load(40);
    pulse(GMIN + 4);
    n = 0;
    while (frame_count < 2 && n < 5000) begin @(negedge clk); n++; end
    check(frame_count == 12'd2 && !done, "R8", "mid-load progress", frame_count, 2);
    @(negedge clk) prgm_n = 0;
    repeat (GMIN + 6) @(negedge clk);
    check(!init_n && frame_count == 0, "R8", "mid-load restart", frame_count, 0);
    expect_load(40);
    prgm_n = 1;
    finish_load("restart", 40, FAST, 5);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule